// File: doc/BRIEF.md
# Write-Only I2C Voltage Set-Point Slave

This block is the control side of a programmable step-down regulator. A host on an I2C bus writes one byte to a fixed 7-bit address, and the low six bits of that byte select the regulator's output set-point in 50 mV steps starting at 0.60 V. The block does not support reads. It never stretches the clock. It accepts only the first data byte of a transfer.

The block samples SCL and SDA with a fast system clock through a two-flop synchronizer and detects START, STOP and SCL edges in that clock domain. When an address byte matches and carries the write bit, the block pulls SDA low through an open-drain enable during the ninth clock. It then does the same for the first data byte. Once that data acknowledge completes, the set-point code register loads and a one-cycle strobe pulses. A decoded millivolt value follows the code and saturates at 2000 mV. An enable input that stays low for a qualifying time marks the regulator off and returns the code to its 1.80 V default.

Top module: `vset_i2c_slave`

## Requirements
- R1: An address byte equal to 7'h14 followed by R/W = 0 (first bit on the wire is the address MSB, the eighth bit is R/W) is acknowledged by a low SDA level during the ninth SCL clock.
- R2: An address byte with any other address, or with R/W = 1, is not acknowledged, and the rest of that transfer causes no acknowledge and no update.
- R3: SDA falling while SCL is high (START) begins a new address phase from any state, including partway through a byte (repeated START). SDA rising while SCL is high (STOP) returns the block to idle.
- R4: The first data byte after an acknowledged address is sampled MSB first on SCL rising edges and is acknowledged. Its bits [5:0] become `code_o`, and bits [7:6] are ignored.
- R5: `code_o` changes, and `upd_o` pulses high for exactly one cycle, only after the data-byte acknowledge clock ends. At no other time does `code_o` change, except on a qualified disable.
- R6: Every data byte after the first in the same transfer is not acknowledged and has no effect.
- R7: `mv_o` equals 600 + 50 × `code_o` for codes 0x00 to 0x1B, and equals 2000 for codes 0x1C to 0x3F.
- R8: After reset, `code_o` is 0x18 and `mv_o` is 1800. `upd_o` and `sda_oe_o` are low.
- R9: When `enable` is low for DIS_CYCLES consecutive clocks, `code_o` returns to 0x18 and `on_o` drops low. A shorter low pulse changes neither. `on_o` is high one cycle after `enable` is high.
- R10: While `enable` is low, bus traffic gets no acknowledge and causes no update. `upd_o` is never high while `on_o` is low.
- R11: `sda_oe_o` rises and falls only while SCL is low. It is released after each ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; a long low period disables and resets the set-point |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | High drives SDA low (open-drain acknowledge) |
| code_o | output | 6 | Registered set-point code |
| mv_o | output | 12 | Set-point in millivolts, saturated at 2000 |
| upd_o | output | 1 | One-cycle strobe when a new code is loaded |
| on_o | output | 1 | Regulator marked on |

## Verification
The acknowledge-edge assertion assumes that SCL stays low for longer than the synchronizer and edge-detect latency (three system clocks). It also assumes that the master never drops `enable` or sends START or STOP while the slave is driving its acknowledge. The stimulus holds every SCL phase for twenty system clocks and changes SDA only while SCL is low, except for deliberate START and STOP conditions. It toggles `enable` only between transfers. The remaining assertions rely only on the register behaviour of the block. They therefore hold for any input pattern.

// File: rtl/vset_pkg.sv
package vset_pkg;

    // Protocol phases of the write-only slave
    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_AACK,
        BUS_DATA,
        BUS_DACK,
        BUS_SKIP
    } bus_st_e;

endpackage

// File: rtl/vset_sync.sv
module vset_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    // Idle bus lines are high, so the chain resets to ones
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= '1;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/vset_bus.sv
module vset_bus
    import vset_pkg::*;
#(
    parameter int          ADDR_W = 7,
    parameter logic [6:0]  ADDR   = 7'h14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_o,
    output logic [7:0] wr_data_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    typedef struct packed {
        bus_st_e    st;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       oe;
        logic       scl_p;
        logic       sda_p;
        logic       wr;
    } bus_s;

    bus_s r_d, r_q;
    logic rise, fall, start, stop;
    logic [7:0] sh_next;

    always_comb begin
        rise    = scl_i & ~r_q.scl_p;
        fall    = ~scl_i & r_q.scl_p;
        start   = scl_i & r_q.scl_p & r_q.sda_p & ~sda_i;
        stop    = scl_i & r_q.scl_p & ~r_q.sda_p & sda_i;
        sh_next = {r_q.sh[6:0], sda_i};

        r_d       = r_q;
        r_d.wr    = 1'b0;
        r_d.scl_p = scl_i;
        r_d.sda_p = sda_i;

        if (!en_i) begin
            r_d.st  = BUS_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (start) begin
            r_d.st  = BUS_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else if (stop) begin
            r_d.st = BUS_IDLE;
            r_d.oe = 1'b0;
        end else begin
            case (r_q.st)
                BUS_ADDR: if (rise) begin
                    r_d.sh  = sh_next;
                    r_d.cnt = r_q.cnt + 3'd1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.st = (sh_next == {ADDR, 1'b0}) ? BUS_AACK : BUS_SKIP;
                    end
                end
                BUS_AACK: if (fall) begin
                    if (!r_q.oe) begin
                        r_d.oe = 1'b1;
                    end else begin
                        r_d.oe  = 1'b0;
                        r_d.st  = BUS_DATA;
                        r_d.cnt = '0;
                    end
                end
                BUS_DATA: if (rise) begin
                    r_d.sh  = sh_next;
                    r_d.cnt = r_q.cnt + 3'd1;
                    if (r_q.cnt == 3'd7) r_d.st = BUS_DACK;
                end
                BUS_DACK: if (fall) begin
                    if (!r_q.oe) begin
                        r_d.oe = 1'b1;
                    end else begin
                        r_d.oe = 1'b0;
                        r_d.st = BUS_SKIP;
                        r_d.wr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: BUS_IDLE, cnt: '0, sh: '0, oe: 1'b0,
                     scl_p: 1'b1, sda_p: 1'b1, wr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o  = r_q.oe;
    assign wr_o      = r_q.wr;
    assign wr_data_o = r_q.sh;

endmodule

// File: rtl/vset_hold.sv
module vset_hold #(
    parameter int              CODE_W     = 6,
    parameter logic [5:0]      DEF_CODE   = 6'h18,
    parameter logic [5:0]      SAT_CODE   = 6'h1C,
    parameter int              BASE_MV    = 600,
    parameter int              STEP_MV    = 50,
    parameter int              MV_W       = 12,
    parameter int              DIS_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [7:0]        wr_data_i,
    output logic [CODE_W-1:0] code_o,
    output logic [MV_W-1:0]   mv_o,
    output logic              upd_o,
    output logic              on_o
);

    localparam int DW = $clog2(DIS_CYCLES + 1);
    localparam logic [DW-1:0] DCNT_LAST = DW'(DIS_CYCLES - 1);
    localparam logic [MV_W-1:0] MAX_MV = MV_W'(BASE_MV + STEP_MV * int'(SAT_CODE));

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
        logic              on;
        logic [DW-1:0]     dcnt;
    } hold_s;

    hold_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.upd = 1'b0;
        if (en_i) begin
            r_d.dcnt = '0;
            r_d.on   = 1'b1;
            if (wr_i) begin
                r_d.code = wr_data_i[CODE_W-1:0];
                r_d.upd  = 1'b1;
            end
        end else if (r_q.dcnt == DCNT_LAST) begin
            r_d.code = CODE_W'(DEF_CODE);
            r_d.on   = 1'b0;
        end else begin
            r_d.dcnt = r_q.dcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{code: CODE_W'(DEF_CODE), upd: 1'b0, on: 1'b0, dcnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.code >= CODE_W'(SAT_CODE)) begin
            mv_o = MAX_MV;
        end else begin
            mv_o = MV_W'(BASE_MV) + MV_W'(STEP_MV) * MV_W'(r_q.code);
        end
    end

    assign code_o = r_q.code;
    assign upd_o  = r_q.upd;
    assign on_o   = r_q.on;

endmodule

// File: rtl/vset_i2c_slave.sv
module vset_i2c_slave #(
    parameter logic [6:0] ADDR       = 7'h14,
    parameter int         CODE_W     = 6,
    parameter logic [5:0] DEF_CODE   = 6'h18,
    parameter logic [5:0] SAT_CODE   = 6'h1C,
    parameter int         BASE_MV    = 600,
    parameter int         STEP_MV    = 50,
    parameter int         MV_W       = 12,
    parameter int         SYNC_STG   = 2,
    parameter int         DIS_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [CODE_W-1:0] code_o,
    output logic [MV_W-1:0]   mv_o,
    output logic              upd_o,
    output logic              on_o
);

    logic [1:0] lines_s;
    logic       wr;
    logic [7:0] wr_data;

    vset_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    vset_bus #(.ADDR_W(7), .ADDR(ADDR)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .scl_i    (lines_s[1]),
        .sda_i    (lines_s[0]),
        .sda_oe_o (sda_oe_o),
        .wr_o     (wr),
        .wr_data_o(wr_data)
    );

    vset_hold #(
        .CODE_W(CODE_W), .DEF_CODE(DEF_CODE), .SAT_CODE(SAT_CODE),
        .BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .MV_W(MV_W),
        .DIS_CYCLES(DIS_CYCLES)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .wr_i     (wr),
        .wr_data_i(wr_data),
        .code_o   (code_o),
        .mv_o     (mv_o),
        .upd_o    (upd_o),
        .on_o     (on_o)
    );

endmodule

// File: rtl/vset_chk.sv
module vset_chk #(
    parameter int         CODE_W   = 6,
    parameter int         MV_W     = 12,
    parameter logic [5:0] DEF_CODE = 6'h18,
    parameter logic [5:0] SAT_CODE = 6'h1C,
    parameter int         BASE_MV  = 600,
    parameter int         STEP_MV  = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic [CODE_W-1:0] code_o,
    input logic [MV_W-1:0]   mv_o,
    input logic              upd_o,
    input logic              on_o
);

    localparam logic [MV_W-1:0] LO_MV = MV_W'(BASE_MV);
    localparam logic [MV_W-1:0] HI_MV = MV_W'(BASE_MV + STEP_MV * int'(SAT_CODE));

    // R11
    ack_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);

    // R5
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> (upd_o || $fell(on_o)));

    // R7
    mv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_o >= LO_MV) && (mv_o <= HI_MV));

    // R10
    upd_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> on_o);

    // R9
    off_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_o) |-> (code_o == CODE_W'(DEF_CODE)));

endmodule

bind vset_i2c_slave vset_chk #(
    .CODE_W(CODE_W), .MV_W(MV_W), .DEF_CODE(DEF_CODE),
    .SAT_CODE(SAT_CODE), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe_o(sda_oe_o),
    .code_o  (code_o),
    .mv_o    (mv_o),
    .upd_o   (upd_o),
    .on_o    (on_o)
);

// File: tb/test_vset_i2c_slave.sv
module test_vset_i2c_slave;

    localparam int HALF   = 20;
    localparam int DIS_CY = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [5:0] code;
    logic [11:0] mv;
    logic       upd;
    logic       on;
    wire        sda_line = sda_oe ? 1'b0 : sda_m;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;

    vset_i2c_slave #(.DIS_CYCLES(DIS_CY)) i_vset_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .code_o  (code),
        .mv_o    (mv),
        .upd_o   (upd),
        .on_o    (on)
    );

    function automatic int mv_of(int c);
        return (c >= 28) ? 2000 : 600 + 50 * c;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl   = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl   = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl   = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(HALF);
            scl   = 1'b1; tick(HALF);
            scl   = 1'b0;
        end
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(HALF);
        scl   = 1'b1; tick(HALF / 2);
        acked = (sda_line == 1'b0);
        tick(HALF / 2);
        scl   = 1'b0;
    endtask

    // driver: pushes the expected code for every write that must land
    task automatic xfer(logic [6:0] a, bit rd, logic [7:0] d,
                        bit exp_a, bit exp_d, string req);
        bit ack;
        bus_start();
        send_byte({a, rd}, ack);
        check(ack == exp_a, req, ack, exp_a);
        if (exp_d) exp_q.push_back(int'(d[5:0]));
        send_byte(d, ack);
        check(ack == exp_d, req, ack, exp_d);
        tick(6);
        check(sda_line == 1'b1, "R11 release", sda_line, 1);
        bus_stop();
        tick(10);
    endtask

    // monitor: pops and compares on every strobe
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && upd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected update", int'(code), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(code) == e, "R4 code", int'(code), e);
                    check(int'(mv) == mv_of(e), "R7 mv", int'(mv), mv_of(e));
                end
                @(negedge clk);
                check(upd == 1'b0, "R5 strobe width", upd, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        tick(5);
        // R8 reset state
        check(code == 6'h18, "R8 code", code, 24);
        check(mv == 12'd1800, "R8 mv", mv, 1800);
        check(upd == 1'b0, "R8 upd", upd, 0);
        check(sda_oe == 1'b0, "R8 oe", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        check(on == 1'b1, "R9 on after enable", on, 1);

        // R1 R4 plain write
        xfer(7'h14, 1'b0, 8'h05, 1'b1, 1'b1, "R1 write 0x05");
        check(code == 6'h05, "R4 held", code, 5);
        // R4 top bits ignored
        xfer(7'h14, 1'b0, 8'hC7, 1'b1, 1'b1, "R4 write 0xC7");
        check(code == 6'h07, "R4 top bits", code, 7);
        // R7 saturation and boundary
        xfer(7'h14, 1'b0, 8'h1B, 1'b1, 1'b1, "R7 write 0x1B");
        xfer(7'h14, 1'b0, 8'h1C, 1'b1, 1'b1, "R7 write 0x1C");
        xfer(7'h14, 1'b0, 8'h3F, 1'b1, 1'b1, "R7 write 0x3F");
        xfer(7'h14, 1'b0, 8'h00, 1'b1, 1'b1, "R7 write 0x00");
        check(mv == 12'd600, "R7 floor", mv, 600);

        // R2 wrong address and read bit
        xfer(7'h15, 1'b0, 8'h09, 1'b0, 1'b0, "R2 wrong addr");
        xfer(7'h0A, 1'b0, 8'h09, 1'b0, 1'b0, "R2 shifted addr");
        xfer(7'h14, 1'b1, 8'h09, 1'b0, 1'b0, "R2 read bit");
        check(code == 6'h00, "R2 no change", code, 0);

        // R6 second byte refused
        bus_start();
        send_byte({7'h14, 1'b0}, ack);
        check(ack, "R6 addr", ack, 1);
        exp_q.push_back(3);
        send_byte(8'h03, ack);
        check(ack, "R6 first data", ack, 1);
        send_byte(8'h11, ack);
        check(!ack, "R6 second data nack", ack, 0);
        bus_stop();
        tick(10);
        check(code == 6'h03, "R6 code", code, 3);

        // R3 repeated START after a refused address
        bus_start();
        send_byte({7'h20, 1'b0}, ack);
        check(!ack, "R3 first addr nack", ack, 0);
        bus_start();
        send_byte({7'h14, 1'b0}, ack);
        check(ack, "R3 repeated start addr", ack, 1);
        exp_q.push_back(2);
        send_byte(8'h02, ack);
        check(ack, "R3 data", ack, 1);
        bus_stop();
        tick(10);

        // R3 repeated START in the middle of a data byte
        bus_start();
        send_byte({7'h14, 1'b0}, ack);
        check(ack, "R3 addr", ack, 1);
        send_bits(8'hFF, 4);
        bus_start();
        send_byte({7'h14, 1'b0}, ack);
        check(ack, "R3 restart addr", ack, 1);
        exp_q.push_back(10);
        send_byte(8'h0A, ack);
        check(ack, "R3 restart data", ack, 1);
        bus_stop();
        tick(10);
        check(code == 6'h0A, "R3 code", code, 10);

        // R9 short enable pulse has no effect
        enable = 1'b0; tick(10); enable = 1'b1; tick(3);
        check(code == 6'h0A, "R9 short pulse code", code, 10);
        check(on == 1'b1, "R9 short pulse on", on, 1);

        // R9 long pulse disables and restores default
        enable = 1'b0; tick(DIS_CY + 20);
        check(code == 6'h18, "R9 default code", code, 24);
        check(mv == 12'd1800, "R9 default mv", mv, 1800);
        check(on == 1'b0, "R9 off", on, 0);

        // R10 bus ignored while disabled
        xfer(7'h14, 1'b0, 8'h04, 1'b0, 1'b0, "R10 disabled write");
        check(code == 6'h18, "R10 code", code, 24);
        enable = 1'b1; tick(3);
        check(on == 1'b1, "R9 back on", on, 1);
        xfer(7'h14, 1'b0, 8'h0C, 1'b1, 1'b1, "R1 after enable");

        tick(50);
        check(exp_q.size() == 0, "R5 all updates seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule